// File: doc/BRIEF.md
# Cascadable presettable binary counter

This block is a synchronous up-counter made of identical 4-bit stages that all update on the rising clock edge. Each stage can be cleared at once by an active-low clear, preset on a clock edge from a data word by an active-low load, or advanced by one. Counting needs two enables to be high together: a parallel enable that every stage shares, and a carry enable that each stage takes from the terminal count of the stage below it.

A stage's terminal count is high only when its carry enable is high and its own 4 bits are all ones. Because the next stage uses it as its carry enable, a chain of stages counts as one wide binary counter. The carry enable of the lowest stage and the terminal count of the highest stage are top-level pins, so chains can be joined further. The stage count is a parameter; with one stage the block is a single 4-bit counter. All pins are plain control and data levels. There is no handshake, because every value is taken on every clock edge and nothing needs to be held back.

Top module: `bincnt_chain`

## Requirements
- R1: While `clr_n` is low, `count` is all zeros and `carry_out` is low at once, without waiting for a clock edge and whatever `load_n`, `cnt_en`, `carry_in` and `load_val` are.
- R2: When `load_n` is low at a rising edge and `clr_n` is high, `count` takes `load_val`, whatever the levels of `cnt_en` and `carry_in`.
- R3: When `load_n` is high and `cnt_en` and `carry_in` are both high at a rising edge, the whole `count` goes up by one.
- R4: When `load_n` is high and either `cnt_en` or `carry_in` is low at a rising edge, `count` keeps its value.
- R5: `carry_out` is high exactly when `carry_in` is high and every bit of `count` is 1. It follows changes of `carry_in` with no clock edge.
- R6: From all ones, a count step wraps `count` to all zeros.
- R7: `count[4*i+3:4*i]` is stage i, and stage 0 is least significant. `stage_tc[i]` is high exactly when `carry_in` is high and `count[4*i+3:0]` is all ones. Stage i+1 counts only on edges where `stage_tc[i]` is high.
- R8: At the first rising edge after `clr_n` goes high, the usual order applies: load first, then count, then hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state updates on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Parallel count enable, shared by all stages |
| carry_in | input | 1 | Carry enable of stage 0 |
| load_val | input | 4*STAGES | Preset data word |
| count | output | 4*STAGES | Counter value, stage 0 in the low bits |
| stage_tc | output | STAGES | Terminal count of each stage |
| carry_out | output | 1 | Terminal count of the top stage |

## Verification
A load and a count step can be called for on the same edge. So can a clear and a load. The bench holds `load_n` low while both enables are high, and checks that `count` takes `load_val` and not the incremented value. It also holds the clear low across edges where load and count are requested, and checks that `count` stays zero. After the clear is released, it checks that the first edge obeys load before count. A cycle-accurate behavioural model of one wide integer gives the expected value on every edge, and it also gives the expected `stage_tc` and `carry_out` just before each edge.

// File: rtl/bincnt_pkg.sv
package bincnt_pkg;
  localparam int unsigned NIBBLE_W = 4;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/bincnt_ctrl.sv
module bincnt_ctrl
  import bincnt_pkg::*;
(
  input  logic    load_n,
  input  logic    par_en,
  input  logic    chain_en,
  output cnt_op_e op
);
  // Load has priority, then count, then hold.
  always_comb begin
    if (!load_n)                 op = OP_LOAD;
    else if (par_en && chain_en) op = OP_COUNT;
    else                         op = OP_HOLD;
  end
endmodule

// File: rtl/bincnt_stage.sv
module bincnt_stage
  import bincnt_pkg::*;
#(
  parameter int unsigned W = NIBBLE_W
)(
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         par_en,
  input  logic         chain_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tc
);
  cnt_op_e op;

  bincnt_ctrl u_ctrl (
    .load_n   (load_n),
    .par_en   (par_en),
    .chain_en (chain_en),
    .op       (op)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else begin
      unique case (op)
        OP_LOAD:  q <= din;
        OP_COUNT: q <= q + W'(1);
        default:  q <= q;
      endcase
    end
  end

  // Terminal count is fed forward from the carry enable, with no clock.
  assign tc = chain_en & (&q);
endmodule

// File: rtl/bincnt_chain.sv
module bincnt_chain
  import bincnt_pkg::*;
#(
  parameter int unsigned STAGES = 3,
  localparam int unsigned DW    = STAGES * NIBBLE_W
)(
  input  logic              clk,
  input  logic              clr_n,
  input  logic              load_n,
  input  logic              cnt_en,
  input  logic              carry_in,
  input  logic [DW-1:0]     load_val,
  output logic [DW-1:0]     count,
  output logic [STAGES-1:0] stage_tc,
  output logic              carry_out
);
  logic [STAGES:0] link;

  assign link[0] = carry_in;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    bincnt_stage #(.W(NIBBLE_W)) u_stage (
      .clk      (clk),
      .clr_n    (clr_n),
      .load_n   (load_n),
      .par_en   (cnt_en),
      .chain_en (link[i]),
      .din      (load_val[i*NIBBLE_W +: NIBBLE_W]),
      .q        (count[i*NIBBLE_W +: NIBBLE_W]),
      .tc       (link[i+1])
    );
    assign stage_tc[i] = link[i+1];
  end

  assign carry_out = link[STAGES];
endmodule

// File: rtl/bincnt_chain_chk.sv
module bincnt_chain_chk #(
  parameter int unsigned STAGES = 3,
  parameter int unsigned DW     = STAGES * 4
)(
  input logic              clk,
  input logic              clr_n,
  input logic              load_n,
  input logic              cnt_en,
  input logic              carry_in,
  input logic [DW-1:0]     load_val,
  input logic [DW-1:0]     count,
  input logic [STAGES-1:0] stage_tc,
  input logic              carry_out
);
  // R1: clear forces zero and a low terminal count, sampled at each edge.
  always @(posedge clk) begin
    if (!clr_n) begin
      a_r1_clear_zero: assert (count == '0);
      a_r1_clear_tc_low: assert (!carry_out);
    end
  end

  // R2 and R8: load wins over both enables.
  a_r2_load_takes_data: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> count == $past(load_val));

  // R3 and R6: a count step adds one to the whole chain, modulo its width.
  a_r3_chain_step: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en && carry_in) |=> count == $past(count) + DW'(1));

  // R4: hold when either enable is low.
  a_r4_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(cnt_en && carry_in)) |=> $stable(count));

  // R5: the top terminal count matches the whole chain at all ones.
  a_r5_carry_out: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out == (carry_in && (&count)));

  // R7: terminal counts of the stages can only drop going up the chain.
  a_r7_tc_monotone: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> (&stage_tc));
endmodule

bind bincnt_chain bincnt_chain_chk #(.STAGES(STAGES), .DW(DW)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .load_n    (load_n),
  .cnt_en    (cnt_en),
  .carry_in  (carry_in),
  .load_val  (load_val),
  .count     (count),
  .stage_tc  (stage_tc),
  .carry_out (carry_out)
);

// File: tb/sim_bincnt_chain.sv
module sim_bincnt_chain;
  localparam int PERIOD = 10;
  localparam int NST    = 3;
  localparam int DW     = NST * 4;
  localparam int MAXV   = (1 << DW) - 1;

  logic clk = 1'b0;
  logic clr_n = 1'b1;
  logic load_n = 1'b1;
  logic cnt_en = 1'b0;
  logic carry_in = 1'b0;
  logic [DW-1:0] load_val = '0;
  logic [DW-1:0] count;
  logic [NST-1:0] stage_tc;
  logic carry_out;
  logic [3:0] count1;
  logic [0:0] stage_tc1;
  logic carry_out1;

  int nchk = 0;
  int nerr = 0;
  int r0 = 0;
  int r1 = 0;

  always #(PERIOD/2) clk = ~clk;

  bincnt_chain #(.STAGES(NST)) u0 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .carry_in(carry_in), .load_val(load_val), .count(count),
    .stage_tc(stage_tc), .carry_out(carry_out)
  );

  bincnt_chain #(.STAGES(1)) u1 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .carry_in(carry_in), .load_val(load_val[3:0]), .count(count1),
    .stage_tc(stage_tc1), .carry_out(carry_out1)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_tc();
    for (int i = 0; i < NST; i++) begin
      int m = (1 << (4*(i+1))) - 1;
      chk("R7", $sformatf("stage_tc[%0d]", i), 32'(stage_tc[i]),
          32'(carry_in && ((r0 & m) == m)));
    end
    chk("R5", "carry_out chain", 32'(carry_out), 32'(carry_in && r0 == MAXV));
    chk("R5", "carry_out single", 32'(carry_out1), 32'(carry_in && r1 == 15));
  endtask

  task automatic cyc(logic c, logic l, logic e, logic ci, logic [DW-1:0] v, string tag);
    @(negedge clk);
    clr_n = c; load_n = l; cnt_en = e; carry_in = ci; load_val = v;
    if (!c) begin r0 = 0; r1 = 0; end
    #1;
    if (!c) begin
      chk("R1", "count under clear", 32'(count), 32'd0);
      chk("R1", "single under clear", 32'(count1), 32'd0);
    end
    check_tc();
    @(posedge clk);
    if (clr_n) begin
      if (!l) begin r0 = int'(v); r1 = int'(v[3:0]); end
      else if (e && ci) begin r0 = (r0 + 1) & MAXV; r1 = (r1 + 1) & 15; end
    end
    #1;
    chk(tag, "count chain", 32'(count), 32'(r0));
    chk(tag, "count single", 32'(count1), 32'(r1));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R1: async clear before any edge, then held across load and count requests
    #2 clr_n = 1'b0;
    #1;
    chk("R1", "reset count", 32'(count), 32'd0);
    chk("R1", "reset carry_out", 32'(carry_out), 32'd0);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 12'hABC, "R1");
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 12'h000, "R1");
    // R8: first edge after release loads, beating count
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 12'h00C, "R8");
    // Single-stage sequence: 13, 14, 15, 0, 1, 2 then inhibit
    for (int k = 0; k < 6; k++) cyc(1'b1, 1'b1, 1'b1, 1'b1, '0, (k == 3) ? "R6" : "R3");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, '0, "R4");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, '0, "R4");
    // R2: load with both enables low and high
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 12'h5A3, "R2");
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 12'h0EF, "R2");
    // R7: ripple across stage boundaries
    for (int k = 0; k < 20; k++) cyc(1'b1, 1'b1, 1'b1, 1'b1, '0, "R7");
    // R6: chain wraps from all ones
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 12'hFFD, "R2");
    for (int k = 0; k < 5; k++) cyc(1'b1, 1'b1, 1'b1, 1'b1, '0, "R6");
    // R5: carry_in toggled at all ones without an edge changing state
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 12'hFFF, "R2");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, '0, "R4");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, '0, "R4");
    // R8: clear then release into a count step
    cyc(1'b0, 1'b1, 1'b1, 1'b1, '0, "R1");
    cyc(1'b1, 1'b1, 1'b1, 1'b1, '0, "R8");
    // Mixed stimulus
    for (int k = 0; k < 600; k++) begin
      logic c, l, e, ci;
      logic [DW-1:0] v;
      string tag;
      c  = ($urandom % 40) != 0;
      l  = ($urandom % 8) != 0;
      e  = ($urandom % 5) != 0;
      ci = ($urandom % 6) != 0;
      v  = DW'($urandom);
      if (!c) tag = "R1";
      else if (!l) tag = "R2";
      else if (e && ci) tag = "R3";
      else tag = "R4";
      cyc(c, l, e, ci, v, tag);
    end
    finish_run();
  end
endmodule